// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Fetch

This block turns an 8-bit interrupt vector into the entry point of its handler. The vector table is a relocatable array of 256 four-byte far pointers. A pulse on `start_i` captures the vector, the table base and the high-memory enable. The block then reads the selected entry as two 16-bit words over a simple request/valid memory port. The first word is the handler offset and the second is the handler segment. It returns both words, along with the physical entry address formed as segment times sixteen plus offset.

When high-memory access is enabled, that sum keeps its carry into bit 20. It can then reach up to 65,520 bytes past the first megabyte. When high-memory access is disabled, bit 20 is forced low, so the address wraps inside the first megabyte. A one-cycle `done_o` pulse marks new results. The results then hold their values until the next fetch completes. Flag and stack pushes, arbitration between interrupt sources and the handler's instruction fetch belong to other blocks.

Top module: `ivt_fetch`

## Requirements
- R1: While `rst_ni` is low and after it rises, `mem_req_o` and `done_o` are 0 and `seg_o`, `off_o`, `phys_o` are 0 until the first fetch completes.
- R2: The first read of a fetch is at byte address base + vector*4, taken modulo 2^ADDR_W. With a base of zero, the table spans 0x0000..0x03FF. `mem_req_o` and `mem_addr_o` stay unchanged until `mem_valid_i` is sampled high.
- R3: The cycle after the first word is accepted, the second read is requested at the first address + 2.
- R4: The word returned by the first read appears on `off_o`, and the word returned by the second read appears on `seg_o`. Bits [7:0] of a word are the byte at the even (lower) address.
- R5: With high-memory access enabled, `phys_o` = segment*16 + offset computed to 21 bits. For example, 0xFFFF:0xFFFF gives 0x10FFEF.
- R6: With high-memory access disabled, `phys_o[20]` is 0 and `phys_o` = (segment*16 + offset) mod 2^20. For example, 0xFFFF:0xFFFF gives 0x0FFEF.
- R7: `done_o` is high for exactly one cycle, in the cycle after the second word is accepted. `seg_o`, `off_o` and `phys_o` change only together with that pulse.
- R8: A `start_i` that arrives while a fetch is running has no effect: no extra read, no change of vector, base or mode, and no extra `done_o`. A fetch is running from the cycle after an accepted start until the second word is accepted.
- R9: Vector, table base and high-memory enable are sampled only in the cycle `start_i` is accepted. Later changes on those inputs do not affect the running fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch (accepted when idle) |
| vec_i | input | 8 | Interrupt vector |
| tbl_base_i | input | ADDR_W | Byte address of the table |
| hma_en_i | input | 1 | 1: keep address bit 20; 0: wrap at 1 MB |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_valid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 16 | Read data word |
| seg_o | output | 16 | Handler segment |
| off_o | output | 16 | Handler offset |
| phys_o | output | 21 | Handler physical address |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checker assumes that `mem_valid_i` is asserted only while `mem_req_o` is high. It also assumes that the memory returns one word per request. The bench's memory responder is built that way: it raises valid only when it sees an open request, and it drops valid after the single cycle in which the word is accepted. The bench varies the response latency from zero to several wait cycles. It applies starts only from tasks that either wait for completion or deliberately collide with a running fetch, so every collision lands inside the busy window.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PHYS_W = 21;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_OFF = 2'd1,
    ST_RD_SEG = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/ivt_entry_addr.sv
module ivt_entry_addr #(
  parameter int unsigned ADDR_W = 21
) (
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [ivt_pkg::VEC_W-1:0] vec_i,
  input  logic                     hi_word_i,
  output logic [ADDR_W-1:0]        addr_o
);
  localparam int unsigned IDX_W = ivt_pkg::VEC_W + 2;
  logic [ADDR_W-1:0] idx;

  // entry byte index = vec*4, plus 2 for the segment word
  assign idx    = {{(ADDR_W-IDX_W){1'b0}}, vec_i, hi_word_i, 1'b0};
  assign addr_o = base_i + idx;
endmodule

// File: rtl/ivt_phys_form.sv
module ivt_phys_form #(
  parameter bit HMA_GATE = 1'b1
) (
  input  logic [ivt_pkg::WORD_W-1:0] seg_i,
  input  logic [ivt_pkg::WORD_W-1:0] off_i,
  input  logic                       hma_en_i,
  output logic [ivt_pkg::PHYS_W-1:0] phys_o
);
  localparam int unsigned PW = ivt_pkg::PHYS_W;
  logic [PW-1:0] sum;

  assign sum = {1'b0, seg_i, 4'h0} + {{(PW-ivt_pkg::WORD_W){1'b0}}, off_i};

  generate
    if (HMA_GATE) begin : g_gate
      assign phys_o = {sum[PW-1] & hma_en_i, sum[PW-2:0]};
    end else begin : g_wrap
      assign phys_o = {1'b0, sum[PW-2:0]};
    end
  endgenerate
endmodule

// File: rtl/ivt_fetch_ctrl.sv
module ivt_fetch_ctrl (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                mem_valid_i,
  output ivt_pkg::fetch_st_e  state_o,
  output logic                accept_o,
  output logic                load_off_o,
  output logic                load_seg_o,
  output logic                req_o,
  output logic                hi_word_o
);
  import ivt_pkg::*;
  fetch_st_e state_q, state_d;

  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign load_off_o = (state_q == ST_RD_OFF) && mem_valid_i;
  assign load_seg_o = (state_q == ST_RD_SEG) && mem_valid_i;
  assign req_o      = (state_q != ST_IDLE);
  assign hi_word_o  = (state_q == ST_RD_SEG);
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i)     state_d = ST_RD_OFF;
      ST_RD_OFF: if (mem_valid_i) state_d = ST_RD_SEG;
      ST_RD_SEG: if (mem_valid_i) state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ivt_fetch.sv
module ivt_fetch #(
  parameter int unsigned ADDR_W   = 21,
  parameter bit          HMA_GATE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        vec_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              hma_en_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [15:0]       mem_rdata_i,
  output logic [15:0]       seg_o,
  output logic [15:0]       off_o,
  output logic [20:0]       phys_o,
  output logic              done_o
);
  import ivt_pkg::*;

  fetch_st_e         state_q;
  logic              accept, load_off, load_seg, hi_word;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] base_q;
  logic              hma_q;
  logic [WORD_W-1:0] off_q, seg_q;
  logic [PHYS_W-1:0] phys_q, phys_d;
  logic              done_q;

  ivt_fetch_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mem_valid_i(mem_valid_i),
    .state_o    (state_q),
    .accept_o   (accept),
    .load_off_o (load_off),
    .load_seg_o (load_seg),
    .req_o      (mem_req_o),
    .hi_word_o  (hi_word)
  );

  ivt_entry_addr #(.ADDR_W(ADDR_W)) u_addr (
    .base_i   (base_q),
    .vec_i    (vec_q),
    .hi_word_i(hi_word),
    .addr_o   (mem_addr_o)
  );

  // phys formed from the incoming segment word and the held offset
  ivt_phys_form #(.HMA_GATE(HMA_GATE)) u_phys (
    .seg_i   (mem_rdata_i),
    .off_i   (off_q),
    .hma_en_i(hma_q),
    .phys_o  (phys_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      base_q <= '0;
      hma_q  <= 1'b0;
    end else if (accept) begin
      vec_q  <= vec_i;
      base_q <= tbl_base_i;
      hma_q  <= hma_en_i;
    end
  end

  // off_q doubles as the working offset; outputs publish together on load_seg
  logic [WORD_W-1:0] off_pub_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q     <= '0;
      off_pub_q <= '0;
      seg_q     <= '0;
      phys_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= load_seg;
      if (load_off) off_q <= mem_rdata_i;
      if (load_seg) begin
        seg_q     <= mem_rdata_i;
        off_pub_q <= off_q;
        phys_q    <= phys_d;
      end
    end
  end

  assign seg_o  = seg_q;
  assign off_o  = off_pub_q;
  assign phys_o = phys_q;
  assign done_o = done_q;
endmodule

// File: rtl/ivt_fetch_chk.sv
module ivt_fetch_chk #(
  parameter int unsigned ADDR_W = 21
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               mem_req_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_valid_i,
  input logic [15:0]        seg_o,
  input logic [15:0]        off_o,
  input logic [20:0]        phys_o,
  input logic               done_o,
  input logic               hma_q,
  input logic [7:0]         vec_q,
  input ivt_pkg::fetch_st_e state_q
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R2

  AST_SEG_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_req_o && mem_valid_i) && mem_req_o
      |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + ADDR_W'(2))); // R3

  AST_WRAP_1MB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !hma_q |-> !phys_o[20]); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({seg_o, off_o, phys_o})); // R7

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ivt_pkg::ST_IDLE |=> $stable(vec_q)); // R8

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && state_q == ivt_pkg::ST_IDLE |=> mem_req_o); // R9
endmodule

bind ivt_fetch ivt_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_valid_i(mem_valid_i),
  .seg_o      (seg_o),
  .off_o      (off_o),
  .phys_o     (phys_o),
  .done_o     (done_o),
  .hma_q      (hma_q),
  .vec_q      (vec_q),
  .state_q    (state_q)
);

// File: tb/ivt_fetch_tb_top.sv
module ivt_fetch_tb_top;
  localparam int AW = 21;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    vec_i = '0;
  logic [AW-1:0] tbl_base_i = '0;
  logic          hma_en_i = 1'b0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_valid_i = 1'b0;
  logic [15:0]   mem_rdata_i = '0;
  logic [15:0]   seg_o, off_o;
  logic [20:0]   phys_o;
  logic          done_o;

  int tests = 0;
  int fails = 0;
  int lat = 0;
  int cycles = 0;
  int n_rd = 0;
  logic [AW-1:0] rd_addr [0:3];
  logic          ov_en = 1'b0;
  logic [15:0]   ov_off = '0, ov_seg = '0;

  always #4ns clk_i = ~clk_i;

  ivt_fetch #(.ADDR_W(AW)) dut_i (.*);

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    if (ov_en) return a[1] ? ov_seg : ov_off;
    return a[16:1] ^ 16'h5A3C ^ {a[4:1], 12'h000};
  endfunction

  // memory responder: valid for one cycle after lat wait cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk_i);
      if (mem_valid_i) mem_valid_i = 1'b0;
      else if (mem_req_o) begin
        if (cnt >= lat) begin
          mem_valid_i = 1'b1;
          mem_rdata_i = mem_word(mem_addr_o);
          if (n_rd < 4) rd_addr[n_rd] = mem_addr_o;
          n_rd++;
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] exp_phys(input logic [15:0] s, input logic [15:0] o, input logic h);
    logic [20:0] v;
    v = {1'b0, s, 4'h0} + {5'h0, o};
    if (!h) v[20] = 1'b0;
    return v;
  endfunction

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done_o && waited < 200) begin
      @(negedge clk_i);
      waited++;
    end
  endtask

  // one full fetch; optional collision start (R8) and input churn (R9) while busy
  task automatic run_fetch(input logic [7:0] v, input logic [AW-1:0] b, input logic h,
                           input int l, input bit collide);
    logic [AW-1:0] ea;
    logic [15:0] eo, es;
    int w;
    lat = l;
    n_rd = 0;
    @(negedge clk_i);
    start_i = 1'b1; vec_i = v; tbl_base_i = b; hma_en_i = h;
    @(negedge clk_i);
    start_i = 1'b0;
    vec_i = ~v; tbl_base_i = b + 21'h1234; hma_en_i = ~h;  // R9 churn
    if (collide) begin
      start_i = 1'b1;  // R8: ignored while busy
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_done(w);
    ea = b + {11'h0, v, 2'b00};
    eo = mem_word(ea);
    es = mem_word(ea + 21'd2);
    check("R7 done", {31'h0, done_o}, 32'h1);
    check("R2 first addr", {11'h0, rd_addr[0]}, {11'h0, ea});
    check("R3 second addr", {11'h0, rd_addr[1]}, {11'h0, ea + 21'd2});
    check("R4 offset", {16'h0, off_o}, {16'h0, eo});
    check("R4 segment", {16'h0, seg_o}, {16'h0, es});
    check(h ? "R5 phys" : "R6 phys", {11'h0, phys_o}, {11'h0, exp_phys(es, eo, h)});
    @(negedge clk_i);
    check("R7 done one cycle", {31'h0, done_o}, 32'h0);
    repeat (3) @(negedge clk_i);
    check("R8 no extra read", n_rd, 2);
    check("R7 hold seg", {16'h0, seg_o}, {16'h0, es});
    check("R7 hold phys", {11'h0, phys_o}, {11'h0, exp_phys(es, eo, h)});
  endtask

  task automatic t_reset();
    check("R1 req", {31'h0, mem_req_o}, 32'h0);
    check("R1 done", {31'h0, done_o}, 32'h0);
    check("R1 outs", {phys_o[15:0], seg_o | off_o}, 32'h0);
  endtask

  task automatic t_hma(input logic h);
    ov_en = 1'b1; ov_off = 16'hFFFF; ov_seg = 16'hFFFF;
    run_fetch(8'h10, 21'h0, h, 1, 1'b0);
    check(h ? "R5 0x10FFEF" : "R6 0x0FFEF", {11'h0, phys_o}, h ? 32'h10FFEF : 32'h0FFEF);
    ov_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_fetch(8'h00, 21'h0, 1'b0, 0, 1'b0);          // table start
    run_fetch(8'hFF, 21'h0, 1'b0, 2, 1'b0);          // last entry 0x3FC
    check("R2 last entry", {11'h0, rd_addr[0]}, 32'h3FC);
    run_fetch(8'h21, 21'h0_8000, 1'b1, 3, 1'b0);     // relocated base
    run_fetch(8'h80, 21'h1F_FF00, 1'b1, 1, 1'b0);    // base wrap mod 2^21
    t_hma(1'b1);
    t_hma(1'b0);
    run_fetch(8'h42, 21'h0_1000, 1'b0, 4, 1'b1);     // collision start
    run_fetch(8'h07, 21'h0, 1'b1, 0, 1'b1);          // collision, zero latency
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk_i);
      cycles++;
    end
    tests++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule